// File: doc/BRIEF.md
# Two-Port Wormhole Flit Router

This block is the path-holding core of one network switch with two input channels and two output channels. Messages travel as a chain of flits. The first flit of a message opens it and names where it goes. The flits after it carry data, and the last flit closes the message. When an opening flit reaches an input, the block picks an output from one bit of its payload. If that output is free, the block claims it and the flit leaves on the next cycle. Every later flit of the same message then goes to the same output, in order, until the closing flit is taken downstream. That event frees the output.

Each input has a single holding register, so the block never buffers a whole packet. If an opening flit wants an output that another message holds, the flit waits in its holding register. Its input then stops accepting, so the rest of its message waits upstream. When both inputs offer an opening flit for the same free output in the same cycle, a round-robin choice picks the winner. All channels use valid/ready handshakes.

Top module: `wh_flit_router`

## Requirements
- R1: In the first cycle after reset is released, both `out_valid` bits are low and both `in_ready` bits are high.
- R2: A flit is `{kind[1:0], payload}`, with the kind in the two most significant bits. Kind bit 0 set means the flit opens a message and bit 1 set means it closes one: 01 opens only, 00 is a middle flit, 10 closes only, 11 is a one-flit message. An opening flit is routed to output 0 when payload bit `ROUTE_BIT` is 0 and to output 1 when that bit is 1.
- R3: When a flit is accepted at an input and its output is free or already owned by its message, it is presented on that output in the next cycle. With ready held high, a message moves at one flit per cycle.
- R4: All flits of a message leave on the output chosen by its opening flit, in arrival order, and none is lost or duplicated.
- R5: While a message owns an output, no flit from the other input appears on that output. An opening flit aimed at an owned output waits in its holding register, and its input's `in_ready` stays low.
- R6: An output is freed by the edge at which its closing flit is accepted downstream. An opening flit already waiting for that output is presented in the very next cycle.
- R7: A one-flit message (kind 11) never leaves its output reserved once it has been accepted.
- R8: If both inputs offer an opening flit for the same free output, the preferred input wins. After reset input 0 is preferred. After each new grant on an output, that output's preference moves to the input that did not win.
- R9: While `out_valid` is high and `out_ready` is low, the output keeps `out_valid` high and holds its flit unchanged.
- R10: `in_ready` is high when that input's holding register is empty, or when the held flit is being accepted downstream in the same cycle.
- R11: The two outputs work independently: messages from different inputs to different outputs advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 2 | Flit offered on input 0 / 1 |
| in_ready | output | 2 | Input 0 / 1 can take a flit |
| in_flit0 | input | PAY_W+2 | Flit on input 0 |
| in_flit1 | input | PAY_W+2 | Flit on input 1 |
| out_valid | output | 2 | Flit presented on output 0 / 1 |
| out_ready | input | 2 | Downstream takes the flit on output 0 / 1 |
| out_flit0 | output | PAY_W+2 | Flit on output 0 |
| out_flit1 | output | PAY_W+2 | Flit on output 1 |

## Verification
Two events can hit one output in the same cycle. One is the release when a closing flit is accepted; the other is a new grant to an opening flit that is already waiting for that output. The bench sets this up by enabling the second input one cycle after the first, so that its opening flit sits blocked behind a four-flit message. It then requires the waiting head to be accepted exactly one cycle after the tail. Contention between two opening flits for a free output is provoked by releasing streams of one-flit messages from both inputs at once, and the bench judges it by the alternating source order recorded on that output. A cycle-level behavioural model compares every output and ready signal in every cycle, including during randomized traffic under back-pressure.

// File: rtl/wh_pkg.sv
package wh_pkg;

  localparam int NPORT = 2;

  typedef enum logic [1:0] {
    K_MID  = 2'b00,
    K_OPEN = 2'b01,
    K_END  = 2'b10,
    K_ONE  = 2'b11
  } kind_e;

  function automatic logic kind_opens(input logic [1:0] k);
    return k[0];
  endfunction

  function automatic logic kind_closes(input logic [1:0] k);
    return k[1];
  endfunction

endpackage

// File: rtl/wh_in_slot.sv
module wh_in_slot #(
  parameter int FLIT_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [FLIT_W-1:0] in_flit,
  output logic              in_ready,
  input  logic              pop,
  output logic              hold_v,
  output logic [FLIT_W-1:0] hold_flit
);

  // one-flit holding stage: refills in the same cycle it drains
  assign in_ready = ~hold_v | pop;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v <= 1'b0;
    end else if (in_valid && in_ready) begin
      hold_v <= 1'b1;
    end else if (pop) begin
      hold_v <= 1'b0;
    end
  end

  // data path carries no reset
  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      hold_flit <= in_flit;
    end
  end

endmodule

// File: rtl/wh_out_chan.sv
module wh_out_chan #(
  parameter int FLIT_W    = 18,
  parameter int ROUTE_BIT = 0,
  parameter int PORT_ID   = 0
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [wh_pkg::NPORT-1:0]            hold_v,
  input  logic [wh_pkg::NPORT-1:0][FLIT_W-1:0] hold_flit,
  input  logic                                out_ready,
  output logic                                out_valid,
  output logic [FLIT_W-1:0]                   out_flit,
  output logic [wh_pkg::NPORT-1:0]            pop,
  output logic                                own_v,
  output logic                                own_src
);
  import wh_pkg::*;

  localparam logic PORT_BIT = PORT_ID[0];

  logic [NPORT-1:0] req;
  logic             pref;
  logic             src;
  logic             acc;
  logic             fresh;

  // opening flits that target this output
  for (genvar i = 0; i < NPORT; i++) begin : g_req
    assign req[i] = hold_v[i] & kind_opens(hold_flit[i][FLIT_W-1 -: 2]) &
                    (hold_flit[i][ROUTE_BIT] == PORT_BIT);
  end

  always_comb begin
    if (own_v) begin
      src       = own_src;
      out_valid = hold_v[own_src];
    end else begin
      src       = (&req) ? pref : req[1];
      out_valid = |req;
    end
    out_flit = hold_flit[src];
    acc      = out_valid & out_ready;
    fresh    = ~own_v & out_valid;
    pop      = '0;
    pop[src] = acc;
  end

  // ownership: taken on grant, dropped when a closing flit leaves
  always_ff @(posedge clk) begin
    if (rst) begin
      own_v   <= 1'b0;
      own_src <= 1'b0;
      pref    <= 1'b0;
    end else begin
      if (acc && kind_closes(out_flit[FLIT_W-1 -: 2])) begin
        own_v <= 1'b0;
      end else if (fresh) begin
        own_v   <= 1'b1;
        own_src <= src;
      end
      if (fresh) begin
        pref <= ~src;
      end
    end
  end

endmodule

// File: rtl/wh_flit_router.sv
module wh_flit_router #(
  parameter  int PAY_W     = 16,
  parameter  int ROUTE_BIT = 0,
  localparam int FLIT_W    = PAY_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        in_valid,
  output logic [1:0]        in_ready,
  input  logic [FLIT_W-1:0] in_flit0,
  input  logic [FLIT_W-1:0] in_flit1,
  output logic [1:0]        out_valid,
  input  logic [1:0]        out_ready,
  output logic [FLIT_W-1:0] out_flit0,
  output logic [FLIT_W-1:0] out_flit1
);
  import wh_pkg::*;

  logic [NPORT-1:0]                        hold_v;
  logic [NPORT-1:0][FLIT_W-1:0]            hold_flit;
  logic [NPORT-1:0][FLIT_W-1:0]            in_flit_v;
  logic [NPORT-1:0][FLIT_W-1:0]            out_flit_v;
  logic [NPORT-1:0][NPORT-1:0]             pop_by;
  logic [NPORT-1:0]                        pop;
  logic [NPORT-1:0]                        own_v;
  logic [NPORT-1:0]                        own_src;

  assign in_flit_v = {in_flit1, in_flit0};
  assign out_flit0 = out_flit_v[0];
  assign out_flit1 = out_flit_v[1];

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    assign pop[i] = pop_by[0][i] | pop_by[1][i];

    wh_in_slot #(.FLIT_W(FLIT_W)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid[i]),
      .in_flit   (in_flit_v[i]),
      .in_ready  (in_ready[i]),
      .pop       (pop[i]),
      .hold_v    (hold_v[i]),
      .hold_flit (hold_flit[i])
    );
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    wh_out_chan #(
      .FLIT_W    (FLIT_W),
      .ROUTE_BIT (ROUTE_BIT),
      .PORT_ID   (o)
    ) u_chan (
      .clk       (clk),
      .rst       (rst),
      .hold_v    (hold_v),
      .hold_flit (hold_flit),
      .out_ready (out_ready[o]),
      .out_valid (out_valid[o]),
      .out_flit  (out_flit_v[o]),
      .pop       (pop_by[o]),
      .own_v     (own_v[o]),
      .own_src   (own_src[o])
    );
  end

endmodule

// File: rtl/wh_router_chk.sv
module wh_router_chk #(
  parameter int FLIT_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        in_ready,
  input logic [1:0]        out_valid,
  input logic [1:0]        out_ready,
  input logic [FLIT_W-1:0] out_flit0,
  input logic [FLIT_W-1:0] out_flit1,
  input logic [1:0]        own_v,
  input logic [1:0]        own_src
);
  import wh_pkg::*;

  logic [1:0][FLIT_W-1:0] oflit;
  logic [1:0]             open_q;

  assign oflit = {out_flit1, out_flit0};

  // message in flight on each output, seen only from the port side
  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= '0;
    end else begin
      for (int o = 0; o < 2; o++) begin
        if (out_valid[o] && out_ready[o]) begin
          if (oflit[o][FLIT_W-1 -: 2] == K_OPEN) open_q[o] <= 1'b1;
          else if (kind_closes(oflit[o][FLIT_W-1 -: 2])) open_q[o] <= 1'b0;
        end
      end
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_valid == 2'b00 && in_ready == 2'b11));

  // R5
  owner_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (own_v == 2'b11) |-> (own_src[0] != own_src[1]));

  for (genvar o = 0; o < 2; o++) begin : g_port
    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid[o] && !out_ready[o]) |=> (out_valid[o] && $stable(oflit[o])));

    // R4
    no_interleave_chk: assert property (@(posedge clk) disable iff (rst)
      (open_q[o] && out_valid[o]) |-> !kind_opens(oflit[o][FLIT_W-1 -: 2]));
  end

endmodule

bind wh_flit_router wh_router_chk #(.FLIT_W(FLIT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_flit0 (out_flit0),
  .out_flit1 (out_flit1),
  .own_v     (own_v),
  .own_src   (own_src)
);

// File: tb/sim_wh_flit_router.sv
`timescale 1ns/1ps
module sim_wh_flit_router;

  localparam int PAY_W = 16;
  localparam int RB    = 0;
  localparam int FW    = PAY_W + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [1:0]    in_valid = '0, in_ready, out_valid, out_ready = '0;
  logic [FW-1:0] in_flit0 = '0, in_flit1 = '0, out_flit0, out_flit1;

  wh_flit_router #(.PAY_W(PAY_W), .ROUTE_BIT(RB)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_flit0(in_flit0), .in_flit1(in_flit1), .out_valid(out_valid),
    .out_ready(out_ready), .out_flit0(out_flit0), .out_flit1(out_flit1)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // behavioural reference state
  bit            m_hv[2];
  logic [FW-1:0] m_hf[2];
  int            m_own[2];
  int            m_pref[2];

  // stimulus and logs
  logic [FW-1:0] srcq[2][$];
  bit            pres[2];
  bit            en_src[2];
  logic [FW-1:0] cur[2];
  int            vin_pct, rdy_pct, cyc, seqn;
  logic [FW-1:0] olog[2][$];
  int            ocyc[2][$];
  int            icyc[2][$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [FW-1:0] mk(input logic [1:0] k, input int s,
                                       input int route, input int idx);
    logic [6:0] sq = seqn[6:0];
    logic [6:0] ix = idx[6:0];
    return {k, sq, s[0], ix, route[0]};
  endfunction

  // nbody < 0 gives a one-flit message
  task automatic push_msg(input int s, input int route, input int nbody);
    if (nbody < 0) begin
      srcq[s].push_back(mk(2'b11, s, route, 0));
    end else begin
      srcq[s].push_back(mk(2'b01, s, route, 0));
      for (int b = 1; b <= nbody; b++) srcq[s].push_back(mk(2'b00, s, route, b));
      srcq[s].push_back(mk(2'b10, s, route, nbody + 1));
    end
    seqn++;
  endtask

  task automatic clear_logs();
    for (int p = 0; p < 2; p++) begin
      olog[p].delete(); ocyc[p].delete(); icyc[p].delete();
    end
  endtask

  task automatic step();
    int src[2];
    bit v[2], acc[2], popm[2], er[2], req[2], was_free;
    logic [FW-1:0] inf[2];
    logic [FW-1:0] of[2];
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      if (!pres[i] && en_src[i] && srcq[i].size() > 0 && int'($urandom % 100) < vin_pct) begin
        cur[i]  = srcq[i].pop_front();
        pres[i] = 1;
      end
    end
    in_valid = {pres[1], pres[0]};
    in_flit0 = cur[0];
    in_flit1 = cur[1];
    for (int o = 0; o < 2; o++) out_ready[o] = (int'($urandom % 100) < rdy_pct);
    #1;
    inf[0] = in_flit0; inf[1] = in_flit1;
    of[0]  = out_flit0; of[1] = out_flit1;
    popm[0] = 0; popm[1] = 0;
    for (int o = 0; o < 2; o++) begin
      src[o] = -1;
      if (m_own[o] >= 0) begin
        src[o] = m_own[o];
        v[o]   = m_hv[src[o]];
      end else begin
        for (int i = 0; i < 2; i++)
          req[i] = m_hv[i] && m_hf[i][FW-2] && (m_hf[i][RB] == o[0]);
        if (req[0] && req[1]) src[o] = m_pref[o];
        else if (req[0])      src[o] = 0;
        else if (req[1])      src[o] = 1;
        v[o] = (src[o] >= 0);
      end
      acc[o] = v[o] && out_ready[o];
      if (acc[o]) popm[src[o]] = 1;
      check(out_valid[o] == v[o], "R5 R6 R8 out_valid", 64'(out_valid[o]), 64'(v[o]));
      if (v[o] && out_valid[o])
        check(of[o] == m_hf[src[o]], "R3 R4 R9 out_flit", 64'(of[o]), 64'(m_hf[src[o]]));
      if (out_valid[o] && out_ready[o]) begin
        olog[o].push_back(of[o]);
        ocyc[o].push_back(cyc);
      end
    end
    for (int i = 0; i < 2; i++) begin
      er[i] = !m_hv[i] || popm[i];
      check(in_ready[i] == er[i], "R10 in_ready", 64'(in_ready[i]), 64'(er[i]));
      if (in_valid[i] && in_ready[i]) icyc[i].push_back(cyc);
    end
    // advance reference state
    for (int o = 0; o < 2; o++) begin
      was_free = (m_own[o] < 0);
      if (acc[o] && m_hf[src[o]][FW-1]) m_own[o] = -1;
      else if (was_free && v[o])        m_own[o] = src[o];
      if (was_free && v[o])             m_pref[o] = 1 - src[o];
    end
    for (int i = 0; i < 2; i++) begin
      if (in_valid[i] && er[i]) begin
        m_hv[i] = 1;
        m_hf[i] = inf[i];
      end else if (popm[i]) begin
        m_hv[i] = 0;
      end
      if (in_valid[i] && in_ready[i]) pres[i] = 0;
    end
    cyc++;
  endtask

  task automatic drain(input int maxc);
    for (int k = 0; k < maxc; k++) begin
      if (srcq[0].size() == 0 && srcq[1].size() == 0 && !pres[0] && !pres[1] &&
          !m_hv[0] && !m_hv[1] && m_own[0] < 0 && m_own[1] < 0) break;
      step();
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R4 watchdog: actual cycles=%0d expected fewer than 150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int total, got;
    logic [FW-1:0] first;
    for (int i = 0; i < 2; i++) begin
      m_hv[i] = 0; m_hf[i] = '0; m_own[i] = -1; m_pref[i] = 0;
      pres[i] = 0; en_src[i] = 1; cur[i] = '0;
    end
    cyc = 0; seqn = 0; vin_pct = 100; rdy_pct = 100;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    check(out_valid == 2'b00, "R1 out_valid after reset", 64'(out_valid), 64'd0);
    check(in_ready == 2'b11, "R1 in_ready after reset", 64'(in_ready), 64'd3);

    // R2 R3 R4: four-flit message from input 0 to output 1, full rate
    clear_logs();
    push_msg(0, 1, 2);
    drain(50);
    check(olog[1].size() == 4, "R4 flit count on output 1", 64'(olog[1].size()), 64'd4);
    check(olog[0].size() == 0, "R2 nothing on output 0", 64'(olog[0].size()), 64'd0);
    for (int k = 0; k < 4 && k < olog[1].size() && k < icyc[0].size(); k++) begin
      check(ocyc[1][k] == icyc[0][k] + 1, "R3 one-cycle pass", 64'(ocyc[1][k]), 64'(icyc[0][k] + 1));
      check(olog[1][k][7:1] == 7'(k), "R4 flit order", 64'(olog[1][k][7:1]), 64'(k));
    end

    // R8: both inputs stream one-flit messages to output 0
    clear_logs();
    for (int k = 0; k < 3; k++) begin
      push_msg(0, 0, -1);
      push_msg(1, 0, -1);
    end
    drain(50);
    check(olog[0].size() == 6, "R8 flit count", 64'(olog[0].size()), 64'd6);
    for (int k = 0; k < olog[0].size(); k++)
      check(olog[0][k][8] == k[0], "R8 round-robin source", 64'(olog[0][k][8]), 64'(k % 2));

    // R5 R6: input 1 head blocked behind input 0 message
    clear_logs();
    en_src[1] = 0;
    push_msg(0, 0, 2);
    push_msg(1, 0, 1);
    step();
    en_src[1] = 1;
    drain(60);
    check(olog[0].size() == 7, "R5 flit count", 64'(olog[0].size()), 64'd7);
    for (int k = 0; k < olog[0].size(); k++)
      check(olog[0][k][8] == (k >= 4), "R5 no interleave", 64'(olog[0][k][8]), 64'(k >= 4));
    if (olog[0].size() == 7)
      check(ocyc[0][4] == ocyc[0][3] + 1, "R6 release then grant", 64'(ocyc[0][4]), 64'(ocyc[0][3] + 1));

    // R11: outputs advance together
    clear_logs();
    push_msg(0, 0, -1);
    push_msg(1, 1, 1);
    drain(50);
    if (olog[0].size() > 0 && olog[1].size() > 0)
      check(ocyc[0][0] == ocyc[1][0], "R11 parallel outputs", 64'(ocyc[0][0]), 64'(ocyc[1][0]));
    else
      check(0, "R11 parallel outputs missing", 64'(olog[0].size()), 64'd1);

    // R7: one-flit message leaves the output free
    clear_logs();
    en_src[1] = 0;
    push_msg(0, 0, -1);
    push_msg(1, 0, 1);
    step();
    en_src[1] = 1;
    drain(50);
    check(olog[0].size() == 4, "R7 later message passes", 64'(olog[0].size()), 64'd4);
    if (olog[0].size() == 4)
      check(ocyc[0][1] == ocyc[0][0] + 1, "R7 no reservation", 64'(ocyc[0][1]), 64'(ocyc[0][0] + 1));

    // R9: back-pressure holds the flit steady
    clear_logs();
    rdy_pct = 0;
    push_msg(0, 0, 1);
    step();
    step();
    first = out_flit0;
    for (int k = 0; k < 4; k++) begin
      step();
      check(out_valid[0] == 1'b1, "R9 valid held", 64'(out_valid[0]), 64'd1);
      check(out_flit0 == first, "R9 flit held", 64'(out_flit0), 64'(first));
    end
    rdy_pct = 100;
    drain(50);

    // random traffic with back-pressure
    clear_logs();
    vin_pct = 70;
    rdy_pct = 60;
    total = 0;
    for (int k = 0; k < 40; k++) begin
      for (int s = 0; s < 2; s++) begin
        int nb = int'($urandom % 6) - 1;
        push_msg(s, int'($urandom % 2), nb);
        total += (nb < 0) ? 1 : nb + 2;
      end
    end
    drain(20000);
    got = olog[0].size() + olog[1].size();
    check(got == total, "R4 all random flits delivered", 64'(got), 64'(total));

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule